// File: doc/BRIEF.md
# Serial Flash Security Register Controller

This block holds the security and status register of a serial NOR flash. Single-byte opcodes arrive through an SPI slave front end that is oversampled by the system clock. A command takes effect only when chip select is released exactly on the byte boundary. The register reports four things:
- sticky program-failure and erase-failure flags;
- a mirror of the array engine's continuous-program state;
- a one-way OTP lock-down bit and a one-way individual-protection-mode bit;
- a factory OTP lock strap.

A stubbed array engine hands program and erase requests to the block over a valid/ready handshake. The block answers each accepted request with a one-cycle `start_o` pulse or a one-cycle `deny_o` pulse. A request is denied when its target is protected.

`req_ready_o` is low while a granted operation is in flight, from the grant until `done_valid_i`. The engine must hold `req_valid_i` and its request fields stable until ready is seen. Denied requests are consumed at once and leave ready high. A read command returns the 8-bit register on MISO.

Top module: `sec_reg_ctrl`

## Requirements
- R1: Register bit order, MSB first: [7] protection-mode select, [6] erase fail, [5] program fail, [4] continuous-program mode (mirrors `cp_mode_i`), [3:2] reserved and read 0, [1] OTP lock-down, [0] factory lock (mirrors `factory_lock_i`).
- R2: A `done_valid_i` with `done_fail_i`=1 that ends a granted program sets bit 5. Bit 5 then stays set through later successful operations.
- R3: A failing `done_valid_i` that ends a granted erase sets bit 6, which is sticky in the same way.
- R4: An accepted request to a protected target produces `deny_o` for one cycle and no `start_o`. It also sets bit 5 for a program or bit 6 for an erase. An accepted request to an unprotected target produces one `start_o` pulse.
- R5: The clear opcode 30h clears bits 6 and 5.
- R6: Opcode 2Fh sets bit 1 without any prior enable command. While bit 1 is 1, every OTP request (`req_otp_i`=1) is denied. Bit 1 never returns to 0, even across `rst_n`.
- R7: While `factory_lock_i` is 1, every OTP request is denied.
- R8: Opcode 68h sets bit 7. Bit 7 never returns to 0, even across `rst_n`.
- R9: With bit 7 set and `wp_n_i` low, every main-array request is denied, whatever `req_sector_locked_i` says. With bit 7 clear, `wp_n_i` has no effect and only `req_sector_locked_i` protects.
- R10: An opcode acts only if chip select rises after exactly 8 SCLK rising edges. A rise after 7 or 9 edges changes no state.
- R11: After opcode 2Bh, the falling SCLK edges shift the register out on MISO, MSB first, starting with the falling edge that ends the opcode byte.
- R12: `rst_n` clears bits 6 and 5 and raises `req_ready_o`. `req_ready_o` is low from a grant until `done_valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled by it |
| rst_n | input | 1 | Active-low power-on reset (volatile state only) |
| sclk_i | input | 1 | SPI serial clock |
| cs_n_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data in, sampled on SCLK rise |
| miso_o | output | 1 | SPI data out, updated on SCLK fall |
| factory_lock_i | input | 1 | Factory OTP lock strap |
| cp_mode_i | input | 1 | Continuous-program state from the engine |
| wp_n_i | input | 1 | Write-protect pin, active low |
| req_valid_i | input | 1 | Engine request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_erase_i | input | 1 | 1 = erase, 0 = program |
| req_otp_i | input | 1 | Target is the OTP area |
| req_sector_locked_i | input | 1 | Target sector lock state |
| start_o | output | 1 | One-cycle grant pulse |
| deny_o | output | 1 | One-cycle deny pulse |
| done_valid_i | input | 1 | Engine reports the end of a granted operation |
| done_fail_i | input | 1 | That operation failed |
| sreg_o | output | 8 | Security register value |

## Verification
The assertions assume three things about the engine:
- it raises `done_valid_i` only while an operation is in flight;
- it keeps `req_valid_i` low during reset;
- it drives SCLK slowly enough for each level to last several system clocks, so the synchronizer sees every edge.

The bench keeps within these rules. Each SCLK half period lasts eight system clocks. Requests wait for ready, and a done pulse is sent only after a grant. Chip select changes only while SCLK is low.

// File: rtl/sec_reg_pkg.sv
package sec_reg_pkg;
  typedef struct packed {
    logic       wp_mode;
    logic       erase_fail;
    logic       prog_fail;
    logic       cp_mode;
    logic [1:0] rsvd;
    logic       otp_locked;
    logic       factory_locked;
  } sec_reg_t;

  localparam logic [7:0] OP_CLR_FLAGS = 8'h30;
endpackage

// File: rtl/spi_opcode_rx.sv
module spi_opcode_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int OP_BITS     = 8,
  parameter logic [OP_BITS-1:0] OP_READ = 8'h2B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               cs_n_i,
  input  logic               mosi_i,
  input  logic [OP_BITS-1:0] rd_data_i,
  output logic               cmd_valid_o,
  output logic [OP_BITS-1:0] cmd_op_o,
  output logic               miso_o
);
  localparam int CW = $clog2(OP_BITS + 2);
  localparam logic [CW-1:0] FULL = CW'(OP_BITS);
  localparam logic [CW-1:0] OVER = CW'(OP_BITS + 1);

  // pin synchronizers: index 2 = cs_n, 1 = sclk, 0 = mosi
  logic [2:0] sync_q [SYNC_STAGES];
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 3'b100;
        else if (g == 0) sync_q[g] <= {cs_n_i, sclk_i, mosi_i};
        else sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  logic s_cs, s_sclk, s_mosi, sclk_d, cs_d;
  assign {s_cs, s_sclk, s_mosi} = sync_q[SYNC_STAGES-1];

  logic edge_up, edge_dn, cs_up;
  assign edge_up = s_sclk & ~sclk_d & ~s_cs;
  assign edge_dn = ~s_sclk & sclk_d & ~s_cs;
  assign cs_up   = s_cs & ~cs_d;

  logic [CW-1:0]      bit_cnt;
  logic [OP_BITS-1:0] shift_q, tx_q, next_shift;
  logic               rd_act;
  assign next_shift = {shift_q[OP_BITS-2:0], s_mosi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0; cs_d <= 1'b1; bit_cnt <= '0; shift_q <= '0;
      tx_q <= '0; rd_act <= 1'b0; miso_o <= 1'b0;
      cmd_valid_o <= 1'b0; cmd_op_o <= '0;
    end else begin
      sclk_d      <= s_sclk;
      cs_d        <= s_cs;
      cmd_valid_o <= cs_up && (bit_cnt == FULL);
      cmd_op_o    <= shift_q;
      if (s_cs) begin
        bit_cnt <= '0;
        rd_act  <= 1'b0;
        miso_o  <= 1'b0;
      end else begin
        if (edge_up) begin
          shift_q <= next_shift;
          if (bit_cnt != OVER) bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == FULL - 1'b1 && next_shift == OP_READ) begin
            rd_act <= 1'b1;
            tx_q   <= rd_data_i;
          end
        end
        if (edge_dn && rd_act) begin
          miso_o <= tx_q[OP_BITS-1];
          tx_q   <= {tx_q[OP_BITS-2:0], 1'b0};
        end
      end
    end
  end

  // R10: a command is issued only from a frame that held exactly one byte
  assert_exact_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(bit_cnt) == FULL);
  assert_cmd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  // R11: MISO only moves while a read is active or on release
  assert_miso_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_act && !s_cs && $past(!rd_act)) |=> $stable(miso_o));
endmodule

// File: rtl/sec_reg_core.sv
module sec_reg_core
  import sec_reg_pkg::*;
#(
  parameter logic [7:0] OP_LOCK_OTP = 8'h2F,
  parameter logic [7:0] OP_WP_MODE  = 8'h68
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid_i,
  input  logic [7:0] cmd_op_i,
  input  logic     factory_lock_i,
  input  logic     cp_mode_i,
  input  logic     wp_n_i,
  input  logic     req_valid_i,
  output logic     req_ready_o,
  input  logic     req_erase_i,
  input  logic     req_otp_i,
  input  logic     req_sector_locked_i,
  output logic     start_o,
  output logic     deny_o,
  input  logic     done_valid_i,
  input  logic     done_fail_i,
  output sec_reg_t sreg_o
);
  // non-volatile bits: no reset, power-up value 0
  logic otp_lock_q = 1'b0;
  logic wp_mode_q  = 1'b0;
  always_ff @(posedge clk) begin
    if (cmd_valid_i && cmd_op_i == OP_LOCK_OTP) otp_lock_q <= 1'b1;
    if (cmd_valid_i && cmd_op_i == OP_WP_MODE)  wp_mode_q  <= 1'b1;
  end

  logic busy_q, op_erase_q, p_fail_q, e_fail_q;
  logic accept, prot, deny_hit, grant, fail_ev, p_set, e_set, clr;

  assign req_ready_o = ~busy_q;
  assign accept   = req_valid_i & req_ready_o;
  assign prot     = req_otp_i ? (otp_lock_q | factory_lock_i)
                              : (req_sector_locked_i | (wp_mode_q & ~wp_n_i));
  assign deny_hit = accept & prot;
  assign grant    = accept & ~prot;
  assign fail_ev  = done_valid_i & done_fail_i & busy_q;
  assign p_set    = (deny_hit & ~req_erase_i) | (fail_ev & ~op_erase_q);
  assign e_set    = (deny_hit & req_erase_i)  | (fail_ev & op_erase_q);
  assign clr      = cmd_valid_i && cmd_op_i == OP_CLR_FLAGS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; op_erase_q <= 1'b0; p_fail_q <= 1'b0; e_fail_q <= 1'b0;
      start_o <= 1'b0; deny_o <= 1'b0;
    end else begin
      start_o <= grant;
      deny_o  <= deny_hit;
      if (grant) begin
        busy_q     <= 1'b1;
        op_erase_q <= req_erase_i;
      end else if (done_valid_i) begin
        busy_q <= 1'b0;
      end
      if (p_set) p_fail_q <= 1'b1;
      else if (clr) p_fail_q <= 1'b0;
      if (e_set) e_fail_q <= 1'b1;
      else if (clr) e_fail_q <= 1'b0;
    end
  end

  always_comb begin
    sreg_o                = '0;
    sreg_o.wp_mode        = wp_mode_q;
    sreg_o.erase_fail     = e_fail_q;
    sreg_o.prog_fail      = p_fail_q;
    sreg_o.cp_mode        = cp_mode_i;
    sreg_o.otp_locked     = otp_lock_q;
    sreg_o.factory_locked = factory_lock_i;
  end

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && deny_o));
  assert_deny_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    deny_o |-> (sreg_o.prog_fail || sreg_o.erase_fail));
  assert_otp_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && req_otp_i && sreg_o.otp_locked) |=> (deny_o && !start_o));
  assert_factory_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && req_otp_i && factory_lock_i) |=> deny_o);
  assert_wp_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sreg_o.wp_mode |=> sreg_o.wp_mode);
  assert_wp_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && !req_otp_i && sreg_o.wp_mode && !wp_n_i) |=> deny_o);
  assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !req_ready_o);
endmodule

// File: rtl/sec_reg_ctrl.sv
module sec_reg_ctrl
  import sec_reg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] OP_READ     = 8'h2B,
  parameter logic [7:0] OP_LOCK_OTP = 8'h2F,
  parameter logic [7:0] OP_WP_MODE  = 8'h68
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       cs_n_i,
  input  logic       mosi_i,
  output logic       miso_o,
  input  logic       factory_lock_i,
  input  logic       cp_mode_i,
  input  logic       wp_n_i,
  input  logic       req_valid_i,
  output logic       req_ready_o,
  input  logic       req_erase_i,
  input  logic       req_otp_i,
  input  logic       req_sector_locked_i,
  output logic       start_o,
  output logic       deny_o,
  input  logic       done_valid_i,
  input  logic       done_fail_i,
  output logic [7:0] sreg_o
);
  logic       cmd_valid;
  logic [7:0] cmd_op;
  sec_reg_t   sreg;
  assign sreg_o = sreg;

  spi_opcode_rx #(.SYNC_STAGES(SYNC_STAGES), .OP_BITS(8), .OP_READ(OP_READ)) u_rx (
    .clk, .rst_n, .sclk_i, .cs_n_i, .mosi_i,
    .rd_data_i(sreg), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .miso_o
  );

  sec_reg_core #(.OP_LOCK_OTP(OP_LOCK_OTP), .OP_WP_MODE(OP_WP_MODE)) u_core (
    .clk, .rst_n, .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .factory_lock_i, .cp_mode_i, .wp_n_i,
    .req_valid_i, .req_ready_o, .req_erase_i, .req_otp_i, .req_sector_locked_i,
    .start_o, .deny_o, .done_valid_i, .done_fail_i, .sreg_o(sreg)
  );
endmodule

// File: tb/test_sec_reg_ctrl.sv
`timescale 1ns/1ps
module test_sec_reg_ctrl;
  localparam int HALF = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 0, cs_n = 1, mosi = 0, miso;
  logic factory_lock = 0, cp_mode = 0, wp_n = 1;
  logic req_valid = 0, req_ready, req_erase = 0, req_otp = 0, req_locked = 0;
  logic start, deny, done_valid = 0, done_fail = 0;
  logic [7:0] sreg;
  int n_run = 0, n_fail = 0;
  int exp_q[$];   // 1 = expect start, 2 = expect deny
  string tag_q[$];

  always #2 clk = ~clk;

  sec_reg_ctrl i_sec_reg_ctrl (
    .clk, .rst_n, .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi), .miso_o(miso),
    .factory_lock_i(factory_lock), .cp_mode_i(cp_mode), .wp_n_i(wp_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_erase_i(req_erase),
    .req_otp_i(req_otp), .req_sector_locked_i(req_locked),
    .start_o(start), .deny_o(deny), .done_valid_i(done_valid),
    .done_fail_i(done_fail), .sreg_o(sreg)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every engine outcome pulse is matched against the scoreboard
  always @(negedge clk) begin
    if (start || deny) begin
      int got;
      got = start ? 1 : 2;
      if (exp_q.size() == 0) check(0, "R4 unexpected outcome", got, 0);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got == e && !(start && deny), t, got, e);
      end
    end
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_frame(input logic [7:0] op, input int nbits);
    cs_n = 0; clks(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = op[7 - (i % 8)];
      clks(HALF); sclk = 1; clks(HALF); sclk = 0;
    end
    clks(HALF); cs_n = 1; clks(3 * HALF);
  endtask

  task automatic read_sreg(output logic [7:0] v);
    cs_n = 0; clks(HALF);
    for (int i = 0; i < 8; i++) begin
      mosi = 8'h2B >> (7 - i);
      clks(HALF); sclk = 1; clks(HALF); sclk = 0;
    end
    for (int i = 0; i < 8; i++) begin
      clks(HALF);
      v[7 - i] = miso;
      sclk = 1; clks(HALF); sclk = 0;
    end
    clks(HALF); cs_n = 1; clks(3 * HALF);
  endtask

  task automatic expect_sreg(input logic [7:0] e, input string tag);
    logic [7:0] v;
    read_sreg(v);
    check(v == e, tag, v, e);
  endtask

  task automatic request(input bit erase, input bit otp, input bit locked,
                         input bit exp_deny, input string tag);
    while (!req_ready) @(negedge clk);
    exp_q.push_back(exp_deny ? 2 : 1);
    tag_q.push_back(tag);
    req_erase = erase; req_otp = otp; req_locked = locked; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    clks(2);
  endtask

  task automatic finish_op(input bit fail);
    done_valid = 1; done_fail = fail;
    @(negedge clk);
    done_valid = 0; done_fail = 0;
    clks(2);
  endtask

  initial begin
    clks(5); rst_n = 1; clks(5);
    check(req_ready == 1, "R12 ready after reset", req_ready, 1);
    expect_sreg(8'h00, "R1 reset value");
    cp_mode = 1;
    expect_sreg(8'h10, "R1 cp mode mirror");
    cp_mode = 0;

    request(0, 0, 0, 0, "R4 grant program");
    check(req_ready == 0, "R12 busy after grant", req_ready, 0);
    finish_op(1);
    check(req_ready == 1, "R12 ready after done", req_ready, 1);
    expect_sreg(8'h20, "R2 program fail");
    request(0, 0, 0, 0, "R4 grant program 2");
    finish_op(0);
    expect_sreg(8'h20, "R2 fail flag sticky");

    spi_frame(8'h30, 7);
    expect_sreg(8'h20, "R10 seven-bit frame ignored");
    spi_frame(8'h30, 9);
    expect_sreg(8'h20, "R10 nine-bit frame ignored");
    spi_frame(8'h30, 8);
    expect_sreg(8'h00, "R5 clear flags");

    request(1, 0, 0, 0, "R3 grant erase");
    finish_op(1);
    expect_sreg(8'h40, "R3 erase fail");
    spi_frame(8'h30, 8);

    request(0, 0, 1, 1, "R4 deny locked program");
    expect_sreg(8'h20, "R4 deny sets program fail");
    request(1, 0, 1, 1, "R4 deny locked erase");
    expect_sreg(8'h60, "R4 deny sets erase fail");
    spi_frame(8'h30, 8);
    expect_sreg(8'h00, "R5 clear both");

    factory_lock = 1;
    request(0, 1, 0, 1, "R7 factory lock denies OTP");
    expect_sreg(8'h21, "R7 factory bit and flag");
    factory_lock = 0;
    spi_frame(8'h30, 8);

    request(0, 1, 0, 0, "R6 OTP open before lock");
    finish_op(0);
    spi_frame(8'h2F, 8);
    expect_sreg(8'h02, "R6 lock-down set");
    request(0, 1, 0, 1, "R6 OTP denied after lock");
    expect_sreg(8'h22, "R6 deny flag");
    spi_frame(8'h30, 8);

    wp_n = 0;
    request(0, 0, 0, 0, "R9 pin ignored in normal mode");
    finish_op(0);
    spi_frame(8'h68, 8);
    expect_sreg(8'h82, "R8 protection mode set");
    request(1, 0, 0, 1, "R9 pin low denies main array");
    wp_n = 1;
    request(0, 0, 0, 0, "R9 pin high grants");
    finish_op(0);
    expect_sreg(8'hC2, "R9 deny sets erase fail");

    rst_n = 0; clks(4); rst_n = 1; clks(4);
    expect_sreg(8'h82, "R12 reset keeps nv bits, clears flags");
    spi_frame(8'h30, 8);
    expect_sreg(8'h82, "R8 R6 bits survive clear");

    clks(10);
    check(exp_q.size() == 0, "R4 all outcomes seen", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule